// File: doc/BRIEF.md
# Multi-Mode Programmable Delay Timer

This block turns a trigger line into a delayed, active-low output line. Four behaviours share one down-counter. Delayed operate holds back the assertion of the output. Delayed release holds back its release. Dual delay holds back both. One-shot turns a rising trigger into a single low pulse of fixed length. The delay is a weight from 0 to 255 multiplied by a prescale factor, which comes from a two-bit select. The delay is counted in base periods.

The clock `clk` runs at twice the base rate, so one base period is two `clk` cycles. Timing in half base periods lets the delay modes add their extra half period without a second clock. A delay mode waits 2·S·W+1 `clk` cycles and a one-shot pulse lasts 2·S·W `clk` cycles. `trig` is taken as already synchronous to `clk`. `rst` is a synchronous, active-high reset of the timer, and it is also the block's only reset.

Top module: `trig_delay_timer`

## Requirements
- R1: Outside one-shot, `outN` settles to the inverse of the `trig` level. Mode codes on `modeSel`: 00 delayed operate, 01 delayed release, 10 dual delay, 11 one-shot.
- R2: A timed change of `outN` in a delay mode occurs 2·S·W+1 clock edges after the edge that first samples the new `trig` level. W is the unsigned value of `weight` (bit k weighs 2^k). With W=0 it occurs on the next edge.
- R3: `scaleSel` picks S. Code 00 gives 1, code 01 gives FACT_LOW, code 10 gives FACT_HIGH, and code 11 also gives 1.
- R4: In delayed operate, high `trig` drives `outN` low after the R2 delay. Low `trig` drives `outN` high on the sampling edge itself and abandons any running count, so the next high restarts the full delay.
- R5: In delayed release, high `trig` drives `outN` low on the sampling edge. Low `trig` drives it high after the R2 delay.
- R6: In dual delay, both transitions take the R2 delay. If `trig` returns to its previous level before the count ends, the count is dropped and `outN` does not change.
- R7: In one-shot, a rising `trig` drives `outN` low from the sampling edge for exactly 2·S·W cycles. W=0 gives no pulse. A falling `trig` has no effect.
- R8: In one-shot, a rising `trig` during a running pulse neither extends nor restarts it.
- R9: While `rst` is high, `outN` is high from the next edge on and any running count is cancelled.
- R10: After `rst` falls, a low `trig` leaves `outN` high in every mode. A high `trig` starts the R2 delay in delayed operate and dual delay. It drives `outN` low at once in delayed release, and leaves `outN` high in one-shot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the base rate |
| rst | input | 1 | Synchronous active-high timer reset |
| modeSel | input | 2 | Operating mode code (R1) |
| scaleSel | input | 2 | Prescale factor code (R3) |
| weight | input | 8 | Binary delay weight W |
| trig | input | 1 | Trigger input, synchronous to clk |
| outN | output | 1 | Delayed active-low output |

## Verification
Every stimulus is applied at a falling clock edge and the result is read at the following falling edges. An immediate response is therefore due at the first falling edge after the stimulus. A delay-mode change is due at falling edge 2·S·W+2, counted from the stimulus edge, and a one-shot pulse reads low on exactly 2·S·W falling edges. The bench counts falling edges until `outN` moves and compares that count with the figure it computes from S and W. This means a result that comes one cycle early or one cycle late fails the check. Stimulus that must have no effect (an aborted count, a retrigger, reset release with a low trigger) is followed by a watch window longer than any delay that could be running.

// File: rtl/dly_timer_pkg.sv
package dly_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OPERATE = 2'b00,
    MODE_RELEASE = 2'b01,
    MODE_DUAL    = 2'b10,
    MODE_ONESHOT = 2'b11
  } dlyMode_e;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic load;     // start a fresh count
    logic stop;     // drop the running count
    logic oneShot;  // length without the extra half period
  } tmrCmd_t;

endpackage

// File: rtl/dly_timer_path.sv
module dly_timer_path
  import dly_timer_pkg::*;
#(
  parameter int FACT_LOW  = 3000,
  parameter int FACT_HIGH = 3600,
  parameter int WEIGHT_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          scaleSel,
  input  logic [WEIGHT_W-1:0] weight,
  input  tmrCmd_t             cmd,
  output logic                active,
  output logic                expired
);

  localparam int MAX_F   = (FACT_LOW > FACT_HIGH) ? FACT_LOW : FACT_HIGH;
  localparam int MAX_LEN = 2 * MAX_F * ((1 << WEIGHT_W) - 1) + 1;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] factor;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] halfTicks;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cnt;
  logic             running;

  // prescale factor select: codes 00 and 11 both mean divide-by-one
  always_comb begin
    unique case (scaleSel)
      2'b01:   factor = CNT_W'(FACT_LOW);
      2'b10:   factor = CNT_W'(FACT_HIGH);
      default: factor = CNT_W'(1);
    endcase
  end

  // half-tick count: 2*S*W, plus one more in the delay modes
  always_comb begin
    span      = factor * CNT_W'(weight);
    halfTicks = {span[CNT_W-2:0], 1'b0};
    loadVal   = cmd.oneShot ? (halfTicks - 1'b1) : halfTicks;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (cmd.stop) begin
      running <= 1'b0;
    end else if (cmd.load) begin
      running <= 1'b1;
      cnt     <= loadVal;
    end else if (running && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign active  = running;
  assign expired = running && (cnt == '0);

  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (running && (cnt != '0) && !cmd.load && !cmd.stop) |=> (cnt == $past(cnt) - 1'b1))
    else $error("count did not step down by one");

  p_oneshot_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd.load && cmd.oneShot) |-> (weight != '0))
    else $error("one-shot started with zero weight");

endmodule

// File: rtl/dly_timer_ctrl.sv
module dly_timer_ctrl
  import dly_timer_pkg::*;
#(
  parameter int WEIGHT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          modeSel,
  input  logic [WEIGHT_W-1:0] weight,
  input  logic                trig,
  input  logic                active,
  input  logic                expired,
  output tmrCmd_t             cmd,
  output logic                outN
);

  dlyMode_e mode;
  logic     trigQ;
  logic     rise;
  logic     mismatch;
  logic     timedEdge;
  logic     outNxt;
  logic     rstQ;

  assign mode      = dlyMode_e'(modeSel);
  assign rise      = trig && !trigQ;
  assign mismatch  = (trig == outN);  // output not yet the inverse of trig
  assign timedEdge = trig ? (mode != MODE_RELEASE) : (mode != MODE_OPERATE);

  always_comb begin
    outNxt      = outN;
    cmd         = '0;
    cmd.oneShot = (mode == MODE_ONESHOT);
    if (mode == MODE_ONESHOT) begin
      if (active) begin
        if (expired) begin
          outNxt   = 1'b1;
          cmd.stop = 1'b1;
        end
      end else if (rise && (weight != '0)) begin
        outNxt   = 1'b0;
        cmd.load = 1'b1;
      end else begin
        outNxt = 1'b1;
      end
    end else if (!mismatch) begin
      cmd.stop = active;
    end else if (!timedEdge) begin
      outNxt   = !trig;
      cmd.stop = active;
    end else if (!active) begin
      cmd.load = 1'b1;
    end else if (expired) begin
      outNxt   = !trig;
      cmd.stop = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    trigQ <= trig;  // captured during reset too: a held trigger is no edge
    rstQ  <= rst;
    if (rst) outN <= 1'b1;
    else     outN <= outNxt;
  end

  always @(posedge clk) begin
    if (rstQ) begin
      p_reset_high_r9: assert (outN) else $error("output low after reset");
    end
  end

  p_operate_fall_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_OPERATE) && !trig) |=> outN)
    else $error("operate mode did not release at once");

  p_release_rise_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_RELEASE) && trig) |=> !outN)
    else $error("release mode did not assert at once");

  p_no_retrig_r8: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_ONESHOT) && active && !expired && !outN) |=> !outN)
    else $error("one-shot pulse cut short");

endmodule

// File: rtl/trig_delay_timer.sv
module trig_delay_timer
  import dly_timer_pkg::*;
#(
  parameter int FACT_LOW  = 3000,
  parameter int FACT_HIGH = 3600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic [1:0] scaleSel,
  input  logic [7:0] weight,
  input  logic       trig,
  output logic       outN
);

  localparam int WEIGHT_W = 8;

  tmrCmd_t cmd;
  logic    active;
  logic    expired;

  dly_timer_ctrl #(.WEIGHT_W(WEIGHT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .modeSel (modeSel),
    .weight  (weight),
    .trig    (trig),
    .active  (active),
    .expired (expired),
    .cmd     (cmd),
    .outN    (outN)
  );

  dly_timer_path #(
    .FACT_LOW  (FACT_LOW),
    .FACT_HIGH (FACT_HIGH),
    .WEIGHT_W  (WEIGHT_W)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .scaleSel (scaleSel),
    .weight   (weight),
    .cmd      (cmd),
    .active   (active),
    .expired  (expired)
  );

endmodule

// File: tb/trig_delay_timer_bench.sv
`timescale 1ns/1ps
module trig_delay_timer_bench;

  localparam int F_LO = 3;
  localparam int F_HI = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic [1:0] scaleSel = 2'b00;
  logic [7:0] weight = 8'd0;
  logic       trig = 1'b0;
  logic       outN;

  int checks = 0;
  int errors = 0;

  trig_delay_timer #(.FACT_LOW(F_LO), .FACT_HIGH(F_HI)) u_trig_delay_timer (
    .clk(clk), .rst(rst), .modeSel(modeSel), .scaleSel(scaleSel),
    .weight(weight), .trig(trig), .outN(outN)
  );

  always #10 clk = ~clk;

  function automatic int factorOf(input int sc);
    if (sc == 1) return F_LO;
    if (sc == 2) return F_HI;
    return 1;
  endfunction

  // cycles from the sampling edge to the output change (R2, R7)
  function automatic int lenOf(input int md, input int sc, input int w);
    return 2 * factorOf(sc) * w + ((md == 3) ? 0 : 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // falling edges until outN leaves fromVal; 0 if it never does within limit
  task automatic waitChange(input logic fromVal, input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (outN !== fromVal) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic doReset(input int md, input int sc, input int w);
    @(negedge clk);
    rst = 1'b1; trig = 1'b0;
    modeSel = 2'(md); scaleSel = 2'(sc); weight = 8'(w);
    repeat (2) @(negedge clk);
    chk("R9 reset level", int'(outN), 1);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int L;
    int wl[6] = '{0, 1, 2, 3, 5, 255};

    // sweep: every mode, every scale code, several weights
    for (int md = 0; md < 4; md++) begin
      for (int sc = 0; sc < 4; sc++) begin
        for (int wi = 0; wi < 6; wi++) begin
          doReset(md, sc, wl[wi]);
          L = lenOf(md, sc, wl[wi]);
          trig = 1'b1;
          if (md == 3) begin
            if (wl[wi] == 0) begin
              waitChange(1'b1, 20, n);
              chk("R7 zero weight no pulse", n, 0);
            end else begin
              waitChange(1'b1, 5, n);
              chk("R7 pulse start", n, 1);
              waitChange(1'b0, L + 5, n);
              chk("R7 R2 R3 pulse width", n, L);
            end
            trig = 1'b0;
            waitChange(1'b1, 20, n);
            chk("R7 fall ignored", n, 0);
          end else begin
            waitChange(1'b1, L + 5, n);
            if (md == 1) chk("R5 rise immediate", n, 1);
            else if (md == 0) chk("R4 R2 R3 rise delay", n, L + 1);
            else chk("R6 R2 R3 rise delay", n, L + 1);
            chk("R1 inverse level high", int'(outN), 0);
            trig = 1'b0;
            waitChange(1'b0, L + 5, n);
            if (md == 0) chk("R4 fall immediate", n, 1);
            else if (md == 1) chk("R5 R2 R3 fall delay", n, L + 1);
            else chk("R6 R2 R3 fall delay", n, L + 1);
            chk("R1 inverse level low", int'(outN), 1);
          end
        end
      end
    end

    // R4: low trigger aborts, next high restarts the full delay
    doReset(0, 2, 2);
    L = lenOf(0, 2, 2);
    trig = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 still high mid count", int'(outN), 1);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 high after abort", int'(outN), 1);
    trig = 1'b1;
    waitChange(1'b1, L + 10, n);
    chk("R4 full restart", n, L + 1);

    // R6: early return drops the count, in both directions
    doReset(2, 2, 2);
    trig = 1'b1;
    repeat (5) @(negedge clk);
    trig = 1'b0;
    waitChange(1'b1, L + 10, n);
    chk("R6 cancelled rise", n, 0);
    trig = 1'b1;
    waitChange(1'b1, L + 10, n);
    chk("R6 rise after cancel", n, L + 1);
    trig = 1'b0;
    repeat (5) @(negedge clk);
    trig = 1'b1;
    waitChange(1'b0, L + 10, n);
    chk("R6 cancelled fall", n, 0);

    // R8: retrigger during pulse
    doReset(3, 2, 2);
    L = lenOf(3, 2, 2);
    begin
      int hiAt = 0;
      int lowAfter = 0;
      int lowFirst = 0;
      trig = 1'b1;
      for (int i = 1; i <= 40; i++) begin
        @(negedge clk);
        if (i == 1) lowFirst = outN ? 0 : 1;
        if (hiAt != 0 && !outN) lowAfter++;
        if (hiAt == 0 && i > 1 && outN) hiAt = i;
        if (i == 4) trig = 1'b0;
        if (i == 6) trig = 1'b1;
      end
      chk("R8 pulse began", lowFirst, 1);
      chk("R8 retrigger not extended", hiAt, L + 1);
      chk("R8 no second pulse", lowAfter, 0);
    end

    // R9: reset cancels a running count
    doReset(0, 2, 2);
    L = lenOf(0, 2, 2);
    trig = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    waitChange(1'b1, L + 10, n);
    chk("R9 count restarted after reset", n, L + 1);

    // R9 forces high at once; R10 low trigger keeps it high
    doReset(2, 2, 2);
    trig = 1'b1;
    waitChange(1'b1, L + 10, n);
    chk("R6 low before reset test", int'(outN), 0);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 forced high", int'(outN), 1);
    rst = 1'b0;
    waitChange(1'b1, L + 10, n);
    chk("R10 trig low stays high", n, 0);

    // R10: reset release with trigger held high, per mode
    for (int md = 0; md < 4; md++) begin
      @(negedge clk);
      rst = 1'b1; trig = 1'b1;
      modeSel = 2'(md); scaleSel = 2'd1; weight = 8'd1;
      repeat (2) @(negedge clk);
      chk("R10 high during reset", int'(outN), 1);
      L = lenOf(md, 1, 1);
      rst = 1'b0;
      waitChange(1'b1, 30, n);
      if (md == 1) chk("R10 release mode immediate", n, 1);
      else if (md == 3) chk("R10 one-shot stays high", n, 0);
      else chk("R10 timed after release", n, L + 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule